// File: doc/BRIEF.md
# Two-Channel Bus Breakpoint Comparator

This block watches every sampled cycle on a processor bus and raises a break request when the cycle meets conditions programmed into it. There are two comparison channels, A and B. Each channel holds a target address with a per-bit ignore mask, an 8-bit address-space tag with an enable, and a cycle qualifier. The qualifier sets which bus master is accepted, fetch or data access, read or write, and the access size. Channel B can also compare the bus data value under its own ignore mask.

The block has two operating modes. In independent mode a hit on either channel raises the break. In sequence mode a hit on channel A only arms the block, and a later hit on channel B raises the break. Software programs the block through a simple register write port. It reads back which channels hit through two sticky flags. The break request is a one-cycle pulse one clock after the matching bus cycle. This lets a fetch break be taken before the fetched instruction executes.

Top module: `bus_break_cmp`

## Requirements
- R1: A channel hits only when every bus address bit whose ignore-mask bit is 0 equals the programmed target bit; address bits whose mask bit is 1 are not compared.
- R2: Qualifier bit 8 enables the tag check against qualifier bits 7:0. When bit 8 is 0, the bus tag does not affect a hit.
- R3: Qualifier bit 9 accepts the CPU as bus master and bit 10 accepts any other master. Bit 11 accepts fetch cycles and bit 12 accepts data cycles. Bits 16:15 select the size: 0 means size is not checked, 1 is byte, 2 is halfword, 3 is word, and the bus size uses the same codes. A cycle whose master, access kind or size is not accepted does not hit.
- R4: Qualifier bit 13 accepts reads and bit 14 accepts writes. A fetch cycle is always treated as a read, so a write-only channel never hits a fetch, even when the bus write line is high.
- R5: During a fetch cycle, a channel whose target address bit 0 is 1 and unmasked never hits.
- R6: On data cycles, channel B also requires the bus data to equal the register at select 6 in every bit where the data mask (select 7) is 0. On fetch cycles the data is not compared.
- R7: In independent mode (control bit 0 = 0), a hit on either channel raises the break and sets that channel's flag.
- R8: In sequence mode (control bit 0 = 1), an A hit sets flag A and arms the block without a break. A B hit while armed raises the break, sets flag B and disarms. A B hit while not armed does nothing.
- R9: A control write that changes the mode bit clears the armed state.
- R10: The break request is a single pulse one clock after the matching cycle is sampled. After reset the break and both flags are 0. The flags stay set until a control write with bit 1 (clears A) or bit 2 (clears B).
- R11: Register selects: channel A uses 0 (address), 1 (mask) and 2 (qualifier); channel B uses 3, 4 and 5; select 8 is control. A register write in the same cycle as a bus cycle does not affect that cycle's comparison; it applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_addr | input | 32 | Bus address |
| bus_data | input | 32 | Bus data value |
| bus_asid | input | 8 | Current address-space tag |
| bus_is_cpu | input | 1 | Cycle is driven by the CPU |
| bus_is_fetch | input | 1 | Cycle is an instruction fetch |
| bus_is_write | input | 1 | Cycle direction is write |
| bus_size | input | 2 | Access size: 1 byte, 2 halfword, 3 word |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register select |
| reg_wdata | input | 32 | Register write data |
| brk_req | output | 1 | Break request pulse |
| match_a | output | 1 | Sticky hit flag of channel A |
| match_b | output | 1 | Sticky hit flag of channel B |

## Verification
Assertions check these rules on every cycle:
- a break only follows a sampled bus cycle and always leaves a hit flag set;
- a sequence-mode break needs a prior armed state and disarms the block;
- a mode change disarms the block;
- a write-only channel A never hits a fetch;
- an odd, unmasked channel A target never hits a fetch.

Only the directed scenarios can show the rest:
- the exact values of address, tag, size and data masking;
- the order of A then B in sequence mode;
- clearing the sticky flags;
- a register write landing in the same cycle as a compared bus cycle not affecting that cycle.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
    localparam int ASID_W    = 8;
    localparam int NCH       = 2;
    localparam int QUAL_W    = 17;
    localparam int SEL_W     = 4;
    localparam int CH_STRIDE = 3;
    localparam int OFS_ADDR  = 0;
    localparam int OFS_MASK  = 1;
    localparam int OFS_QUAL  = 2;
    localparam int SEL_DVAL  = 6;
    localparam int SEL_DMASK = 7;
    localparam int SEL_CTRL  = 8;
    localparam int DATA_CH   = 1;

    localparam int QB_RD    = 13;
    localparam int QB_WR    = 14;
    localparam int QB_FETCH = 11;
    localparam int QB_DATA  = 12;

    typedef struct packed {
        logic [1:0]        size;
        logic              dir_wr;
        logic              dir_rd;
        logic              acc_data;
        logic              acc_fetch;
        logic              mst_oth;
        logic              mst_cpu;
        logic              asid_en;
        logic [ASID_W-1:0] asid;
    } qual_t;
endpackage

// File: rtl/bkpt_regs.sv
module bkpt_regs
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int WR_W   = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             reg_we,
    input  logic [SEL_W-1:0]                 reg_sel,
    input  logic [WR_W-1:0]                  reg_wdata,
    output logic [NCH-1:0][ADDR_W-1:0]       addr_o,
    output logic [NCH-1:0][ADDR_W-1:0]       amask_o,
    output logic [NCH-1:0][QUAL_W-1:0]       qual_o,
    output logic [DATA_W-1:0]                dval_o,
    output logic [DATA_W-1:0]                dmask_o,
    output logic                             seq_o,
    output logic                             mode_chg_o,
    output logic                             clr_a_o,
    output logic                             clr_b_o
);
    typedef struct packed {
        logic [NCH-1:0][ADDR_W-1:0] addr;
        logic [NCH-1:0][ADDR_W-1:0] amask;
        logic [NCH-1:0][QUAL_W-1:0] qual;
        logic [DATA_W-1:0]          dval;
        logic [DATA_W-1:0]          dmask;
        logic                       seq;
    } rf_t;

    rf_t  rf_d, rf_q;
    logic ctrl_wr;

    always_comb begin
        rf_d    = rf_q;
        ctrl_wr = reg_we && (reg_sel == SEL_W'(SEL_CTRL));
        if (reg_we) begin
            for (int ch = 0; ch < NCH; ch++) begin
                if (reg_sel == SEL_W'(ch * CH_STRIDE + OFS_ADDR))
                    rf_d.addr[ch] = reg_wdata[ADDR_W-1:0];
                if (reg_sel == SEL_W'(ch * CH_STRIDE + OFS_MASK))
                    rf_d.amask[ch] = reg_wdata[ADDR_W-1:0];
                if (reg_sel == SEL_W'(ch * CH_STRIDE + OFS_QUAL))
                    rf_d.qual[ch] = reg_wdata[QUAL_W-1:0];
            end
            if (reg_sel == SEL_W'(SEL_DVAL))  rf_d.dval  = reg_wdata[DATA_W-1:0];
            if (reg_sel == SEL_W'(SEL_DMASK)) rf_d.dmask = reg_wdata[DATA_W-1:0];
        end
        if (ctrl_wr) rf_d.seq = reg_wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    assign addr_o     = rf_q.addr;
    assign amask_o    = rf_q.amask;
    assign qual_o     = rf_q.qual;
    assign dval_o     = rf_q.dval;
    assign dmask_o    = rf_q.dmask;
    assign seq_o      = rf_q.seq;
    assign mode_chg_o = ctrl_wr && (reg_wdata[0] != rf_q.seq);
    assign clr_a_o    = ctrl_wr && reg_wdata[1];
    assign clr_b_o    = ctrl_wr && reg_wdata[2];
endmodule

// File: rtl/bkpt_chan_cmp.sv
module bkpt_chan_cmp
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [ADDR_W-1:0] tgt_mask,
    input  logic [QUAL_W-1:0] qual_raw,
    input  logic              data_ok,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [ASID_W-1:0] bus_asid,
    input  logic              bus_is_cpu,
    input  logic              bus_is_fetch,
    input  logic              bus_is_write,
    input  logic [1:0]        bus_size,
    output logic              hit
);
    qual_t q;
    logic  addr_ok, asid_ok, mst_ok, acc_ok, dir_ok, size_ok, eff_wr, odd_fetch;

    always_comb begin
        q         = qual_t'(qual_raw);
        addr_ok   = ((bus_addr ^ tgt_addr) & ~tgt_mask) == '0;
        asid_ok   = !q.asid_en || (bus_asid == q.asid);
        mst_ok    = bus_is_cpu ? q.mst_cpu : q.mst_oth;
        acc_ok    = bus_is_fetch ? q.acc_fetch : q.acc_data;
        eff_wr    = bus_is_write && !bus_is_fetch;
        dir_ok    = eff_wr ? q.dir_wr : q.dir_rd;
        size_ok   = (q.size == 2'd0) || (q.size == bus_size);
        odd_fetch = bus_is_fetch && tgt_addr[0] && !tgt_mask[0];
        hit       = addr_ok && asid_ok && mst_ok && acc_ok && dir_ok
                    && size_ok && data_ok && !odd_fetch;
    end
endmodule

// File: rtl/bkpt_seq.sv
module bkpt_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_valid,
    input  logic hit_a,
    input  logic hit_b,
    input  logic seq_mode,
    input  logic mode_chg,
    input  logic clr_a,
    input  logic clr_b,
    output logic brk_req,
    output logic flag_a,
    output logic flag_b,
    output logic armed
);
    typedef struct packed {
        logic armed;
        logic flag_a;
        logic flag_b;
        logic brk;
    } seq_t;

    seq_t st_d, st_q;
    logic va, vb, set_a, set_b;

    always_comb begin
        st_d = st_q;
        va   = bus_valid && hit_a;
        vb   = bus_valid && hit_b;
        if (seq_mode) begin
            st_d.brk = vb && st_q.armed;
            set_a    = va;
            set_b    = st_d.brk;
        end else begin
            st_d.brk = va || vb;
            set_a    = va;
            set_b    = vb;
        end
        if (!seq_mode || mode_chg || st_d.brk) st_d.armed = 1'b0;
        else if (va)                           st_d.armed = 1'b1;
        st_d.flag_a = (st_q.flag_a && !clr_a) || set_a;
        st_d.flag_b = (st_q.flag_b && !clr_b) || set_b;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign brk_req = st_q.brk;
    assign flag_a  = st_q.flag_a;
    assign flag_b  = st_q.flag_b;
    assign armed   = st_q.armed;
endmodule

// File: rtl/bus_break_cmp.sv
module bus_break_cmp
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int WR_W  = (ADDR_W > DATA_W) ? ADDR_W : DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic [ASID_W-1:0] bus_asid,
    input  logic              bus_is_cpu,
    input  logic              bus_is_fetch,
    input  logic              bus_is_write,
    input  logic [1:0]        bus_size,
    input  logic              reg_we,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [WR_W-1:0]   reg_wdata,
    output logic              brk_req,
    output logic              match_a,
    output logic              match_b
);
    logic [NCH-1:0][ADDR_W-1:0] addr_w, amask_w;
    logic [NCH-1:0][QUAL_W-1:0] qual_w;
    logic [DATA_W-1:0]          dval_w, dmask_w;
    logic                       seq_w, mode_chg_w, clr_a_w, clr_b_w, armed_w;
    logic [NCH-1:0]             hit_w, dok_w;

    bkpt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_W(WR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .addr_o(addr_w), .amask_o(amask_w),
        .qual_o(qual_w), .dval_o(dval_w), .dmask_o(dmask_w), .seq_o(seq_w),
        .mode_chg_o(mode_chg_w), .clr_a_o(clr_a_w), .clr_b_o(clr_b_w)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        if (ch == DATA_CH) begin : g_data
            assign dok_w[ch] = bus_is_fetch || (((bus_data ^ dval_w) & ~dmask_w) == '0);
        end else begin : g_nodata
            assign dok_w[ch] = 1'b1;
        end
        bkpt_chan_cmp #(.ADDR_W(ADDR_W)) u_cmp (
            .tgt_addr(addr_w[ch]), .tgt_mask(amask_w[ch]), .qual_raw(qual_w[ch]),
            .data_ok(dok_w[ch]), .bus_addr(bus_addr), .bus_asid(bus_asid),
            .bus_is_cpu(bus_is_cpu), .bus_is_fetch(bus_is_fetch),
            .bus_is_write(bus_is_write), .bus_size(bus_size), .hit(hit_w[ch])
        );
    end

    bkpt_seq u_seq (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .hit_a(hit_w[0]),
        .hit_b(hit_w[1]), .seq_mode(seq_w), .mode_chg(mode_chg_w),
        .clr_a(clr_a_w), .clr_b(clr_b_w), .brk_req(brk_req),
        .flag_a(match_a), .flag_b(match_b), .armed(armed_w)
    );
endmodule

// File: rtl/bkpt_chk.sv
module bkpt_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_valid,
    input logic       bus_is_fetch,
    input logic       brk_req,
    input logic       match_a,
    input logic       match_b,
    input logic       seq_q,
    input logic       armed_q,
    input logic       mode_chg,
    input logic [1:0] hit,
    input logic       a_wr_only,
    input logic       a_odd_tgt
);
    AST_BRK_FOLLOWS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_valid) |-> !brk_req); // R10
    AST_BRK_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> (match_a || match_b)); // R7
    AST_SEQ_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_req && $past(seq_q)) |-> $past(armed_q)); // R8
    AST_SEQ_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_req && $past(seq_q)) |-> !armed_q); // R8
    AST_MODE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mode_chg) |-> !armed_q); // R9
    AST_FETCH_NOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_is_fetch && a_wr_only) |-> !hit[0]); // R4
    AST_ODD_FETCH_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_is_fetch && a_odd_tgt) |-> !hit[0]); // R5
endmodule

bind bus_break_cmp bkpt_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_is_fetch(bus_is_fetch),
    .brk_req(brk_req), .match_a(match_a), .match_b(match_b), .seq_q(seq_w),
    .armed_q(armed_w), .mode_chg(mode_chg_w), .hit(hit_w),
    .a_wr_only(qual_w[0][bkpt_pkg::QB_WR] & ~qual_w[0][bkpt_pkg::QB_RD]),
    .a_odd_tgt(addr_w[0][0] & ~amask_w[0][0])
);

// File: tb/bus_break_cmp_tb_top.sv
`timescale 1ns/1ps
module bus_break_cmp_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_data = '0;
    logic [7:0]  bus_asid = '0;
    logic        bus_is_cpu = 1'b0;
    logic        bus_is_fetch = 1'b0;
    logic        bus_is_write = 1'b0;
    logic [1:0]  bus_size = '0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic        brk_req, match_a, match_b;
    int          checks = 0;
    int          errors = 0;

    always #4 clk = ~clk;

    bus_break_cmp dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .bus_data(bus_data), .bus_asid(bus_asid), .bus_is_cpu(bus_is_cpu),
        .bus_is_fetch(bus_is_fetch), .bus_is_write(bus_is_write),
        .bus_size(bus_size), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .brk_req(brk_req), .match_a(match_a),
        .match_b(match_b)
    );

    function automatic logic [31:0] mkq(input logic [7:0] asid, input logic en,
        input logic cpu, input logic oth, input logic fet, input logic dat,
        input logic rd, input logic wr, input logic [1:0] size);
        return {15'd0, size, wr, rd, dat, fet, oth, cpu, en, asid};
    endfunction

    localparam logic [31:0] QANY = 32'h0000_7E00;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] sel, input logic [31:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic cfg(input int ch, input logic [31:0] a, input logic [31:0] m,
                       input logic [31:0] q);
        wr(4'(ch * 3 + 0), a);
        wr(4'(ch * 3 + 1), m);
        wr(4'(ch * 3 + 2), q);
    endtask

    task automatic cyc(input logic [31:0] a, input logic [31:0] d, input logic [7:0] asid,
                       input logic cpu, input logic fet, input logic w, input logic [1:0] sz,
                       input logic exp, input string req);
        @(negedge clk);
        bus_valid = 1'b1; bus_addr = a; bus_data = d; bus_asid = asid;
        bus_is_cpu = cpu; bus_is_fetch = fet; bus_is_write = w; bus_size = sz;
        @(negedge clk);
        bus_valid = 1'b0;
        chk(req, {31'd0, brk_req}, {31'd0, exp});
    endtask

    task automatic t_reset;
        chk("R10 reset brk", {31'd0, brk_req}, 32'd0);
        chk("R10 reset flag a", {31'd0, match_a}, 32'd0);
        chk("R10 reset flag b", {31'd0, match_b}, 32'd0);
    endtask

    task automatic t_addr_mask;
        wr(4'd8, 32'h6);
        cfg(0, 32'h1000_0100, 32'h0000_00FF, QANY);
        cfg(1, 32'h0, 32'h0, 32'h0);
        cyc(32'h1000_01AB, 0, 0, 1, 0, 0, 2'd3, 1'b1, "R1 masked bits ignored");
        cyc(32'h1000_0200, 0, 0, 1, 0, 0, 2'd3, 1'b0, "R1 unmasked bit differs");
        cyc(32'h1000_0000, 0, 0, 1, 0, 0, 2'd3, 1'b0, "R1 bit 8 differs");
        chk("R10 flag a sticky", {31'd0, match_a}, 32'd1);
        chk("R10 flag b untouched", {31'd0, match_b}, 32'd0);
        wr(4'd8, 32'h6);
        chk("R10 flag a cleared", {31'd0, match_a}, 32'd0);
    endtask

    task automatic t_asid;
        cfg(0, 32'h2000, 32'h0, mkq(8'h80, 1, 1, 1, 1, 1, 1, 1, 2'd0));
        cyc(32'h2000, 0, 8'h70, 1, 0, 0, 2'd1, 1'b0, "R2 tag mismatch");
        cyc(32'h2000, 0, 8'h80, 1, 0, 0, 2'd1, 1'b1, "R2 tag match");
        wr(4'd2, mkq(8'h80, 0, 1, 1, 1, 1, 1, 1, 2'd0));
        cyc(32'h2000, 0, 8'h70, 1, 0, 0, 2'd1, 1'b1, "R2 tag check off");
    endtask

    task automatic t_qual;
        cfg(0, 32'h3000, 32'h0, mkq(0, 0, 1, 0, 0, 1, 1, 1, 2'd2));
        cyc(32'h3000, 0, 0, 0, 0, 0, 2'd2, 1'b0, "R3 other master rejected");
        cyc(32'h3000, 0, 0, 1, 1, 0, 2'd2, 1'b0, "R3 fetch rejected");
        cyc(32'h3000, 0, 0, 1, 0, 0, 2'd3, 1'b0, "R3 word size rejected");
        cyc(32'h3000, 0, 0, 1, 0, 0, 2'd1, 1'b0, "R3 byte size rejected");
        cyc(32'h3000, 0, 0, 1, 0, 0, 2'd2, 1'b1, "R3 cpu data halfword");
    endtask

    task automatic t_fetch_dir;
        cfg(0, 32'h3400, 32'h0, mkq(0, 0, 1, 1, 1, 1, 0, 1, 2'd0));
        cyc(32'h3400, 0, 0, 1, 1, 1, 2'd2, 1'b0, "R4 fetch is never write");
        cyc(32'h3400, 0, 0, 1, 0, 1, 2'd2, 1'b1, "R4 data write");
        cyc(32'h3400, 0, 0, 1, 0, 0, 2'd2, 1'b0, "R4 data read rejected");
        wr(4'd2, mkq(0, 0, 1, 1, 1, 1, 1, 0, 2'd0));
        cyc(32'h3400, 0, 0, 1, 1, 1, 2'd2, 1'b1, "R4 fetch counts as read");
    endtask

    task automatic t_odd;
        cfg(0, 32'h0003_7227, 32'h0, mkq(0, 0, 1, 1, 1, 0, 1, 0, 2'd0));
        cyc(32'h0003_7227, 0, 0, 1, 1, 0, 2'd2, 1'b0, "R5 odd fetch target");
        wr(4'd1, 32'h1);
        cyc(32'h0003_7226, 0, 0, 1, 1, 0, 2'd2, 1'b1, "R5 odd bit masked");
        wr(4'd0, 32'h0003_7226);
        wr(4'd1, 32'h0);
        cyc(32'h0003_7226, 0, 0, 1, 1, 0, 2'd2, 1'b1, "R5 even fetch target");
    endtask

    task automatic t_data;
        wr(4'd8, 32'h6);
        cfg(0, 32'h0, 32'h0, 32'h0);
        cfg(1, 32'h4000, 32'h0, mkq(0, 0, 1, 1, 0, 1, 1, 1, 2'd0));
        wr(4'd6, 32'h1234_5678);
        wr(4'd7, 32'h0000_00FF);
        cyc(32'h4000, 32'h1234_56AA, 0, 1, 0, 0, 2'd3, 1'b1, "R6 masked data byte");
        cyc(32'h4000, 32'h1235_5678, 0, 1, 0, 0, 2'd3, 1'b0, "R6 data mismatch");
        chk("R7 flag b set", {31'd0, match_b}, 32'd1);
        wr(4'd5, mkq(0, 0, 1, 1, 1, 1, 1, 1, 2'd0));
        cyc(32'h4000, 32'hDEAD_BEEF, 0, 1, 1, 0, 2'd2, 1'b1, "R6 data ignored on fetch");
    endtask

    task automatic t_indep;
        wr(4'd8, 32'h6);
        cfg(0, 32'h5000, 32'h0, QANY);
        cfg(1, 32'h6000, 32'h0, QANY);
        wr(4'd7, 32'hFFFF_FFFF);
        cyc(32'h6000, 0, 0, 1, 0, 0, 2'd3, 1'b1, "R7 channel b alone");
        chk("R7 flag a clear", {31'd0, match_a}, 32'd0);
        chk("R7 flag b set", {31'd0, match_b}, 32'd1);
        cyc(32'h5000, 0, 0, 1, 0, 0, 2'd3, 1'b1, "R7 channel a alone");
        chk("R7 flag a set", {31'd0, match_a}, 32'd1);
    endtask

    task automatic t_seq;
        wr(4'd8, 32'h7);
        cyc(32'h6000, 0, 0, 1, 0, 0, 2'd3, 1'b0, "R8 b before a");
        chk("R8 flag b stays clear", {31'd0, match_b}, 32'd0);
        cyc(32'h5000, 0, 0, 1, 0, 0, 2'd3, 1'b0, "R8 a only arms");
        chk("R8 flag a set", {31'd0, match_a}, 32'd1);
        cyc(32'h6000, 0, 0, 1, 0, 0, 2'd3, 1'b1, "R8 b after a");
        chk("R8 flag b set", {31'd0, match_b}, 32'd1);
        cyc(32'h6000, 0, 0, 1, 0, 0, 2'd3, 1'b0, "R8 disarmed after break");
    endtask

    task automatic t_mode;
        cyc(32'h5000, 0, 0, 1, 0, 0, 2'd3, 1'b0, "R9 arm");
        wr(4'd8, 32'h6);
        wr(4'd8, 32'h7);
        cyc(32'h6000, 0, 0, 1, 0, 0, 2'd3, 1'b0, "R9 mode change disarms");
    endtask

    task automatic t_same_cycle;
        wr(4'd8, 32'h6);
        cfg(0, 32'h7000, 32'h0, QANY);
        cfg(1, 32'h0, 32'h0, 32'h0);
        @(negedge clk);
        bus_valid = 1'b1; bus_addr = 32'h7000; bus_is_cpu = 1'b1;
        bus_is_fetch = 1'b0; bus_is_write = 1'b0; bus_size = 2'd3;
        reg_we = 1'b1; reg_sel = 4'd0; reg_wdata = 32'h7100;
        @(negedge clk);
        bus_valid = 1'b0; reg_we = 1'b0;
        chk("R11 old target used", {31'd0, brk_req}, 32'd1);
        @(negedge clk);
        chk("R10 single pulse", {31'd0, brk_req}, 32'd0);
        cyc(32'h7000, 0, 0, 1, 0, 0, 2'd3, 1'b0, "R11 old target gone");
        cyc(32'h7100, 0, 0, 1, 0, 0, 2'd3, 1'b1, "R11 new target");
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_addr_mask();
        t_asid();
        t_qual();
        t_fetch_dir();
        t_odd();
        t_data();
        t_indep();
        t_seq();
        t_mode();
        t_same_cycle();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule